// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

A combinational execution unit for a scalar integer pipeline. It takes a first operand, a second operand that has already passed through the barrel shifter, the shifter's carry-out and the current four condition flags. A 4-bit opcode selects one of sixteen operations and a set-flags bit enables the flag update. The block returns the result, a write-enable for the destination register, and the next value of the four flags.

The arithmetic group covers add, subtract and reverse subtract. Each has a plain form and a form that consumes the carry flag. In the subtract forms, carry acts as an inverted borrow. The logical group covers AND, XOR, OR, move, move-inverted and bit-clear. Four compare/test opcodes evaluate a subtraction, an addition, an AND or an XOR only to set the flags, and never write a result.

Wide additions are built by chaining: a flag-setting add of the low words, then an add-with-carry of the high words that uses the carry flag it returned. The datapath width is a parameter, and a second parameter chooses a bit-level ripple adder or an inferred adder.

Top module: `dp_alu`

## Requirements
- R1: Opcodes 0000 AND, 0001 XOR, 1100 OR, 1101 move, 1110 bit-clear (first AND NOT second) and 1111 move-inverted (NOT second) produce the named bitwise result.
- R2: Opcodes 0100 add (first+second), 0010 subtract (first-second) and 0011 reverse subtract (second-first) produce the modulo-2^WIDTH result.
- R3: Opcodes 0101 add-with-carry (first+second+C), 0110 subtract-with-carry (first-second-(1-C)) and 0111 reverse-subtract-with-carry (second-first-(1-C)) use the incoming C flag.
- R4: After an arithmetic operation that updates flags, C is the unsigned carry-out for additions. For subtractions, C is 1 when no borrow occurs and 0 when one does (5-3 gives C=1, 3-5 gives C=0).
- R5: After an arithmetic operation that updates flags, V is 1 exactly when the signed result overflows WIDTH bits.
- R6: When flags update, N equals the top bit of the computed value and Z is 1 exactly when that value is zero. The flag vector packs N at bit 3, Z at bit 2, C at bit 1 and V at bit 0.
- R7: After a logical operation that updates flags, C equals the shifter carry-out and V keeps its incoming value.
- R8: Opcodes 1000 test (AND), 1001 test-equal (XOR), 1010 compare (subtract) and 1011 compare-negated (add) never assert the write-enable, and they always update the flags whatever the set-flags bit.
- R9: For the other twelve opcodes with set-flags 0, the flag output equals the flag input.
- R10: The twelve non-compare opcodes always assert the write-enable.
- R11: A 64-bit sum is obtained as a flag-setting add of the low words followed by an add-with-carry of the high words.
- R12: A flag-setting move of zero gives Z=1, N=0, and leaves C and V unchanged when the shifter carry-out equals the incoming C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Shifted second operand |
| sh_carry | input | 1 | Carry-out of the barrel shifter |
| flags_in | input | 4 | Current N,Z,C,V (bits 3..0) |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Enables the flag update |
| result | output | WIDTH | Operation result |
| result_we | output | 1 | Destination write-enable |
| flags_out | output | 4 | Next N,Z,C,V (bits 3..0) |

## Verification
The block holds no state, so a wrong internal decode or carry path shows at the ports in the same evaluation as the stimulus that exercises it. An inverted borrow sense or a misrouted carry-in shows at once in the C flag and in the result of the carry forms. A wrong operand swap shows in the reverse-subtract results. An exhaustive sweep of a 4-bit instance reaches every operand pair, every opcode and every relevant flag input, so each such fault appears within the sweep. A directed 32-bit pass checks the borrow examples and the chained 64-bit add.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
      OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
      OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
      OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
   } alu_op_e;

   // carry-in source of the adder
   typedef enum logic [1:0] {
      CIN_ZERO = 2'd0,
      CIN_ONE  = 2'd1,
      CIN_FLAG = 2'd2
   } cin_sel_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   typedef struct packed {
      logic     arith;    // result comes from the adder
      logic     swap;     // adder sees (second, first)
      logic     invert;   // adder inverts its second input
      cin_sel_e cin_sel;
      logic     writes;   // destination is written
      logic     force_fl; // flags update regardless of set-flags
   } dec_t;

endpackage

// File: rtl/dpalu_decode.sv
module dpalu_decode
   import dpalu_pkg::*;
(
   input  logic [3:0] opcode,
   output dec_t       dec
);

   alu_op_e op;
   assign op = alu_op_e'(opcode);

   always_comb begin
      dec          = '0;
      dec.writes   = 1'b1;
      dec.cin_sel  = CIN_ZERO;
      unique case (op)
         OP_ADD: begin
            dec.arith = 1'b1;
         end
         OP_ADC: begin
            dec.arith   = 1'b1;
            dec.cin_sel = CIN_FLAG;
         end
         OP_SUB: begin
            dec.arith   = 1'b1;
            dec.invert  = 1'b1;
            dec.cin_sel = CIN_ONE;
         end
         OP_SBC: begin
            dec.arith   = 1'b1;
            dec.invert  = 1'b1;
            dec.cin_sel = CIN_FLAG;
         end
         OP_RSB: begin
            dec.arith   = 1'b1;
            dec.swap    = 1'b1;
            dec.invert  = 1'b1;
            dec.cin_sel = CIN_ONE;
         end
         OP_RSC: begin
            dec.arith   = 1'b1;
            dec.swap    = 1'b1;
            dec.invert  = 1'b1;
            dec.cin_sel = CIN_FLAG;
         end
         OP_CMP: begin
            dec.arith    = 1'b1;
            dec.invert   = 1'b1;
            dec.cin_sel  = CIN_ONE;
            dec.writes   = 1'b0;
            dec.force_fl = 1'b1;
         end
         OP_CMN: begin
            dec.arith    = 1'b1;
            dec.writes   = 1'b0;
            dec.force_fl = 1'b1;
         end
         OP_TST, OP_TEQ: begin
            dec.writes   = 1'b0;
            dec.force_fl = 1'b1;
         end
         default: begin
            dec.arith = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/dpalu_adder.sv
module dpalu_adder #(
   parameter int unsigned WIDTH  = 32,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             swap,
   input  logic             invert,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);

   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] x;
   logic [WIDTH-1:0] y_raw;
   logic [WIDTH-1:0] y;

   assign x     = swap ? b : a;
   assign y_raw = swap ? a : b;
   assign y     = invert ? ~y_raw : y_raw;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = x[i] ^ y[i] ^ chain[i];
            assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
         end
         assign cout = chain[WIDTH];

         always_comb begin
            // R4
            ripple_sum_chk: assert ({cout, sum} ==
                                    ({1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin}))
               else $error("ripple chain disagrees with arithmetic sum");
         end
      end else begin : g_infer
         logic [WIDTH:0] full;
         assign full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
         assign sum  = full[MSB:0];
         assign cout = full[WIDTH];
      end
   endgenerate

   assign ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

endmodule

// File: rtl/dpalu_logic.sv
module dpalu_logic
   import dpalu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [3:0]       opcode,
   output logic [WIDTH-1:0] res
);

   alu_op_e op;
   assign op = alu_op_e'(opcode);

   always_comb begin
      case (op)
         OP_AND, OP_TST: res = a & b;
         OP_EOR, OP_TEQ: res = a ^ b;
         OP_ORR:         res = a | b;
         OP_MOV:         res = b;
         OP_BIC:         res = a & ~b;
         OP_MVN:         res = ~b;
         default:        res = '0;
      endcase
   end

endmodule

// File: rtl/dpalu_flags.sv
module dpalu_flags
   import dpalu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] value,
   input  logic             arith,
   input  logic             add_cout,
   input  logic             add_ovf,
   input  logic             sh_carry,
   input  nzcv_t            fin,
   input  logic             update,
   output nzcv_t            fout
);

   nzcv_t fresh;

   always_comb begin
      fresh.n = value[WIDTH-1];
      fresh.z = ~|value;
      fresh.c = arith ? add_cout : sh_carry;
      fresh.v = arith ? add_ovf : fin.v;
      fout    = update ? fresh : fin;
   end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dpalu_pkg::*;
#(
   parameter int unsigned WIDTH  = 32,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             sh_carry,
   input  logic [3:0]       flags_in,
   input  logic [3:0]       opcode,
   input  logic             set_flags,
   output logic [WIDTH-1:0] result,
   output logic             result_we,
   output logic [3:0]       flags_out
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dp_alu: WIDTH must be at least 2");
      end
   endgenerate

   dec_t             dec;
   logic [WIDTH-1:0] add_sum;
   logic             add_cout;
   logic             add_ovf;
   logic             cin;
   logic [WIDTH-1:0] log_res;
   logic [WIDTH-1:0] value;
   nzcv_t            fin;
   nzcv_t            fout;

   assign fin = nzcv_t'(flags_in);

   dpalu_decode u_dec (
      .opcode (opcode),
      .dec    (dec)
   );

   always_comb begin
      case (dec.cin_sel)
         CIN_ONE:  cin = 1'b1;
         CIN_FLAG: cin = fin.c;
         default:  cin = 1'b0;
      endcase
   end

   dpalu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .a      (opa),
      .b      (opb),
      .swap   (dec.swap),
      .invert (dec.invert),
      .cin    (cin),
      .sum    (add_sum),
      .cout   (add_cout),
      .ovf    (add_ovf)
   );

   dpalu_logic #(.WIDTH(WIDTH)) u_log (
      .a      (opa),
      .b      (opb),
      .opcode (opcode),
      .res    (log_res)
   );

   assign value = dec.arith ? add_sum : log_res;

   dpalu_flags #(.WIDTH(WIDTH)) u_flg (
      .value    (value),
      .arith    (dec.arith),
      .add_cout (add_cout),
      .add_ovf  (add_ovf),
      .sh_carry (sh_carry),
      .fin      (fin),
      .update   (set_flags | dec.force_fl),
      .fout     (fout)
   );

   assign result    = value;
   assign result_we = dec.writes;
   assign flags_out = fout;

   always_comb begin
      // R8
      if (opcode[3:2] == 2'b10) begin
         cmp_no_write_chk: assert (!result_we)
            else $error("compare/test opcode asserted write-enable");
      end
      // R9
      if (!set_flags && result_we) begin
         hold_flags_chk: assert (flags_out == flags_in)
            else $error("flags changed without set-flags");
      end
      // R7
      if (set_flags && !dec.arith) begin
         logic_carry_chk: assert (flags_out[1] == sh_carry && flags_out[0] == flags_in[0])
            else $error("logical op did not take shifter carry / keep V");
      end
      // R6
      if (set_flags || !result_we) begin
         zero_flag_chk: assert (flags_out[2] == (result == '0))
            else $error("Z flag disagrees with result");
      end
   end

endmodule

// File: tb/tb_dp_alu.sv
module tb_dp_alu;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;
   localparam int NW         = 4;
   localparam int WW         = 32;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // narrow exhaustive instance (ripple adder)
   logic [NW-1:0] a_n, b_n, r_n;
   logic          shc_n, s_n, we_n;
   logic [3:0]    fi_n, op_n, fo_n;

   dp_alu #(.WIDTH(NW), .RIPPLE(1'b1)) dut (
      .opa(a_n), .opb(b_n), .sh_carry(shc_n), .flags_in(fi_n),
      .opcode(op_n), .set_flags(s_n),
      .result(r_n), .result_we(we_n), .flags_out(fo_n)
   );

   // wide directed instance (inferred adder)
   logic [WW-1:0] a_w, b_w, r_w;
   logic          shc_w, s_w, we_w;
   logic [3:0]    fi_w, op_w, fo_w;

   dp_alu #(.WIDTH(WW)) dut_wide (
      .opa(a_w), .opb(b_w), .sh_carry(shc_w), .flags_in(fi_w),
      .opcode(op_w), .set_flags(s_w),
      .result(r_w), .result_we(we_w), .flags_out(fo_w)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // reference computed from the requirements with integer arithmetic
   function automatic void model(input int w, input int op, input longint ua,
                                 input longint ub, input bit shc,
                                 input logic [3:0] fin, input bit s,
                                 output longint res, output bit we,
                                 output logic [3:0] fo, output bit arith);
      longint full = 64'sd1 <<< w;
      longint mask = full - 1;
      longint half = full >>> 1;
      longint sa = (ua >= half) ? ua - full : ua;
      longint sb = (ub >= half) ? ub - full : ub;
      longint cc = longint'(fin[1]);
      longint u = 0, sv = 0;
      bit is_sub = 1'b0, cy, ov, upd;
      arith = 1'b1;
      case (op)
         4, 11: begin u = ua + ub;          sv = sa + sb;          end
         5:     begin u = ua + ub + cc;     sv = sa + sb + cc;     end
         2, 10: begin u = ua - ub;          sv = sa - sb;          is_sub = 1'b1; end
         6:     begin u = ua - ub - (1-cc); sv = sa - sb - (1-cc); is_sub = 1'b1; end
         3:     begin u = ub - ua;          sv = sb - sa;          is_sub = 1'b1; end
         7:     begin u = ub - ua - (1-cc); sv = sb - sa - (1-cc); is_sub = 1'b1; end
         default: arith = 1'b0;
      endcase
      if (arith) begin
         res = u & mask;
         cy  = is_sub ? (u >= 0) : (u > mask);
         ov  = (sv > half - 1) || (sv < -half);
      end else begin
         case (op)
            0, 8:  res = ua & ub;
            1, 9:  res = ua ^ ub;
            12:    res = ua | ub;
            13:    res = ub;
            14:    res = ua & (~ub & mask);
            default: res = ~ub & mask;
         endcase
         cy = shc;
         ov = fin[0];
      end
      we  = !(op >= 8 && op <= 11);
      upd = s || !we;
      fo  = upd ? {res[w-1], res == 0, cy, ov} : fin;
   endfunction

   function automatic string res_req(input int op);
      if (op == 5 || op == 6 || op == 7) return "R3";
      if (op >= 2 && op <= 4) return "R2";
      return "R1";
   endfunction

   task automatic check_narrow(input int op, input int a, input int b,
                               input bit shc, input logic [3:0] fin, input bit s);
      longint er; bit ew; logic [3:0] ef; bit ar;
      model(NW, op, a, b, shc, fin, s, er, ew, ef, ar);
      check((op >= 8 && op <= 11) ? "R8" : "R10", "we", we_n, ew);
      if (ew) check(res_req(op), "result", r_n, er);
      if (!ew || s) begin
         check("R6", "N", fo_n[3], ef[3]);
         check("R6", "Z", fo_n[2], ef[2]);
         check(ar ? "R4" : "R7", "C", fo_n[1], ef[1]);
         check(ar ? "R5" : "R7", "V", fo_n[0], ef[0]);
      end else begin
         check("R9", "flags", fo_n, ef);
      end
   endtask

   task automatic drive_wide(input int op, input logic [WW-1:0] a,
                             input logic [WW-1:0] b, input bit shc,
                             input logic [3:0] fin, input bit s);
      @(posedge clk);
      #1;
      op_w = op[3:0]; a_w = a; b_w = b; shc_w = shc; fi_w = fin; s_w = s;
      #(CLK_PERIOD/2);
   endtask

   task automatic wide_vs_model(input int op, input logic [WW-1:0] a,
                                input logic [WW-1:0] b, input bit shc,
                                input logic [3:0] fin, input bit s);
      longint er; bit ew; logic [3:0] ef; bit ar;
      drive_wide(op, a, b, shc, fin, s);
      model(WW, op, longint'(a), longint'(b), shc, fin, s, er, ew, ef, ar);
      if (ew) check(res_req(op), "wide result", r_w, er);
      check(ar ? "R5" : "R7", "wide flags", fo_w, ef);
   endtask

   initial begin
      a_n = '0; b_n = '0; shc_n = 0; fi_n = '0; op_n = '0; s_n = 0;
      a_w = '0; b_w = '0; shc_w = 0; fi_w = '0; op_w = '0; s_w = 0;
      #(CLK_PERIOD/2 + 1);
      // idle state: AND of zeros, no flag update
      check("R10", "idle we", we_n, 1);
      check("R9", "idle flags", fo_n, 0);

      // exhaustive sweep on the narrow instance
      for (int op = 0; op < 16; op++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               for (int k = 0; k < 16; k++) begin
                  logic [3:0] fin;
                  fin = {k[3] ^ a[0], k[2] ^ b[0], k[1], k[0]};
                  @(posedge clk);
                  #1;
                  op_n = op[3:0]; a_n = a[3:0]; b_n = b[3:0];
                  shc_n = k[2]; s_n = k[3]; fi_n = fin;
                  #(CLK_PERIOD/2);
                  check_narrow(op, a, b, k[2], fin, k[3]);
               end

      // R4: borrow examples, 5-3 and 3-5 on the wide instance
      drive_wide(2, 32'd5, 32'd3, 0, 4'b0000, 1);
      check("R4", "5-3 result", r_w, 2);
      check("R4", "5-3 C", fo_w[1], 1);
      drive_wide(2, 32'd3, 32'd5, 0, 4'b0000, 1);
      check("R4", "3-5 result", r_w, 32'hFFFF_FFFE);
      check("R4", "3-5 C", fo_w[1], 0);
      check("R6", "3-5 N", fo_w[3], 1);

      // R11: 64-bit add 0x1_FFFFFFFF + 0x2_00000001 = 0x4_00000000
      begin
         logic [WW-1:0] lo, hi;
         logic [3:0]    f;
         drive_wide(4, 32'hFFFF_FFFF, 32'h0000_0001, 0, 4'b0000, 1);
         lo = r_w; f = fo_w;
         drive_wide(5, 32'h0000_0001, 32'h0000_0002, 0, f, 0);
         hi = r_w;
         check("R11", "64-bit sum", {hi, lo}, 64'h4_0000_0000);
      end

      // R12: flag-setting move of zero, C and V preserved
      drive_wide(13, '0, '0, 1, 4'b1011, 1);
      check("R12", "movs0 result", r_w, 0);
      check("R12", "movs0 flags", fo_w, 4'b0111);

      // R5: signed overflow at full width
      wide_vs_model(4, 32'h7FFF_FFFF, 32'h0000_0001, 0, 4'b0000, 1);
      wide_vs_model(2, 32'h8000_0000, 32'h0000_0001, 0, 4'b0000, 1);
      wide_vs_model(7, 32'h1234_5678, 32'h8765_4321, 1, 4'b0000, 1);
      wide_vs_model(14, 32'hFFFF_0000, 32'h0F0F_0F0F, 1, 4'b0001, 1);
      wide_vs_model(10, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 4'b1001, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule